// File: doc/BRIEF.md
# Guest Bus Strobe Timing Generator

This block drives the access strobe and chip selects of a small peripheral bus that serves four attached slaves ("guests"). A requester presents a guest number and a read/write flag. When the block is ready it accepts the request and copies that guest's two timing codes out of a 16-bit configuration word. One code sets how long the strobe stays asserted and the other sets the quiet gap that follows before the next access may start. Both codes use the same non-linear table: 3, 4, 12 or 15 clock cycles.

The sequencer has three named states. `ST_IDLE` is the only state that accepts a request; the transition *accept* (valid request while idle) leads to `ST_STROBE`. `ST_STROBE` holds the read or write strobe and the guest's chip select for the decoded duration; the transition *strobe_end* (cycle counter reaches zero) leads to `ST_RECOVER` and, on that same edge, raises a one-cycle completion pulse and captures the guest's read data. `ST_RECOVER` keeps everything quiet for the decoded recovery count; the transition *recover_end* (counter reaches zero) returns to `ST_IDLE`. With no request pending, `ST_IDLE` stays where it is.

Top module: `guest_strobe_gen`

## Requirements
- R1: After reset the block is in `ST_IDLE`: `req_ready` is 1, `busy` is 0, both strobes are 0, `guest_cs` is 0, `done` is 0 and `rd_data` is 0.
- R2: A timing code maps to a cycle count as 2'b00 = 3, 2'b01 = 4, 2'b10 = 12, 2'b11 = 15, identically for duration and recovery; a reset configuration of all zeros therefore gives 3 and 3.
- R3: Guest g owns bits [4g+3:4g] of `timing_cfg`; within that nibble bits [4g+3:4g+2] are the duration code and bits [4g+1:4g] are the recovery code.
- R4: A request accepted at a clock edge (`req_valid` high while `req_ready` is high) asserts the strobe from that edge for exactly the decoded duration; `rd_strobe` is used when `req_write` is 0 and `wr_strobe` when it is 1, never both, and `guest_cs` is one-hot with bit g set for exactly the strobe cycles.
- R5: After the strobe falls, `req_ready` stays low for exactly the decoded recovery count and then returns high.
- R6: A request presented while `req_ready` is low is not taken: no additional strobe is produced for it.
- R7: The timing codes and guest number are captured at acceptance; changing `timing_cfg` during an access does not alter that access's duration or recovery.
- R8: `done` is high for exactly one cycle, the first cycle after the strobe falls, and at no other time.
- R9: For a read, `rd_data` takes the value on `rd_data_in` at the edge where the strobe falls and holds it; a write leaves `rd_data` unchanged.
- R10: `busy` is always the inverse of `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_cfg | input | 16 | Packed duration/recovery codes for guests 0..3 |
| req_valid | input | 1 | Access request |
| req_guest | input | 2 | Guest number of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | High when a request will be accepted |
| busy | output | 1 | High while an access or its recovery is in progress |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| guest_cs | output | 4 | One-hot chip select, valid during the strobe |
| done | output | 1 | One-cycle completion pulse |
| rd_data_in | input | 16 | Data returned by the guest |
| rd_data | output | 16 | Read data captured at strobe end |

## Verification
Counting from the accepting edge, the strobe and chip select are visible right after that edge, fall after the duration count of edges, and in the sample just after the falling edge `done` is high and `rd_data` already holds the captured value; `req_ready` returns high after a further recovery count of edges. The bench samples every output 1 ns after each rising edge, so each sample reflects the edge just passed, and the monitor measures strobe and recovery lengths by counting those samples. The driver checks the strobe one sample after acceptance and queues the expected guest, direction, counts and data, which the monitor pops when a strobe rises and compares when it falls.

// File: rtl/gsg_pkg.sv
package gsg_pkg;

    localparam int CODE_W  = 2;
    localparam int FIELD_W = 2 * CODE_W;
    localparam int CNT_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } gsg_state_e;

endpackage

// File: rtl/gsg_code_decode.sv
module gsg_code_decode
    import gsg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [W-1:0]      cycles
);

    // R2: non-linear code table shared by duration and recovery
    always_comb begin
        unique case (code)
            2'b00:   cycles = W'(3);
            2'b01:   cycles = W'(4);
            2'b10:   cycles = W'(12);
            default: cycles = W'(15);
        endcase
    end

endmodule

// File: rtl/gsg_cycle_counter.sv
module gsg_cycle_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/guest_strobe_gen.sv
module guest_strobe_gen
    import gsg_pkg::*;
#(
    parameter  int NUM_GUESTS = 4,
    parameter  int DATA_W     = 16,
    localparam int GSEL_W     = $clog2(NUM_GUESTS),
    localparam int CFG_W      = NUM_GUESTS * FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      timing_cfg,
    input  logic                  req_valid,
    input  logic [GSEL_W-1:0]     req_guest,
    input  logic                  req_write,
    output logic                  req_ready,
    output logic                  busy,
    output logic                  rd_strobe,
    output logic                  wr_strobe,
    output logic [NUM_GUESTS-1:0] guest_cs,
    output logic                  done,
    input  logic [DATA_W-1:0]     rd_data_in,
    output logic [DATA_W-1:0]     rd_data
);

    gsg_state_e state, state_nxt;

    logic [FIELD_W-1:0] fld [NUM_GUESTS];
    logic [FIELD_W-1:0] sel_fld;
    logic [GSEL_W-1:0]  lat_guest;
    logic               lat_wr;
    logic [CODE_W-1:0]  lat_rec_code;
    logic [CNT_W-1:0]   dur_now;
    logic [CNT_W-1:0]   rec_lat;
    logic [CNT_W-1:0]   lat_dur_cycles;
    logic               accept;
    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_val;
    logic               cnt_zero;
    logic               strobe_end;

    // R3: slice the configuration word into one nibble per guest
    for (genvar g = 0; g < NUM_GUESTS; g++) begin : g_field
        assign fld[g] = timing_cfg[g*FIELD_W +: FIELD_W];
    end

    assign sel_fld = fld[req_guest];
    assign accept  = req_valid && (state == ST_IDLE);

    gsg_code_decode #(.W(CNT_W)) u_dec_dur (
        .code   (sel_fld[FIELD_W-1:CODE_W]),
        .cycles (dur_now)
    );

    gsg_code_decode #(.W(CNT_W)) u_dec_rec (
        .code   (lat_rec_code),
        .cycles (rec_lat)
    );

    gsg_cycle_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and counter loads
    always_comb begin
        state_nxt  = state;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        strobe_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = ST_STROBE;
                    cnt_load  = 1'b1;
                    cnt_val   = dur_now - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    state_nxt  = ST_RECOVER;
                    cnt_load   = 1'b1;
                    cnt_val    = rec_lat - 1'b1;
                    strobe_end = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // R7: capture the request and its codes at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_guest      <= '0;
            lat_wr         <= 1'b0;
            lat_rec_code   <= '0;
            lat_dur_cycles <= CNT_W'(3);
        end else if (accept) begin
            lat_guest      <= req_guest;
            lat_wr         <= req_write;
            lat_rec_code   <= sel_fld[CODE_W-1:0];
            lat_dur_cycles <= dur_now;
        end
    end

    // R8, R9: completion pulse and read capture on the strobe's last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= strobe_end;
            if (strobe_end && !lat_wr) begin
                rd_data <= rd_data_in;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        guest_cs  = '0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_STROBE: begin
                rd_strobe           = !lat_wr;
                wr_strobe           = lat_wr;
                guest_cs[lat_guest] = 1'b1;
            end
            ST_RECOVER: req_ready = 1'b0;
            default:    req_ready = 1'b0;
        endcase
        busy = !req_ready;
    end

    // ---------------- assertions ----------------
    logic             strobe_any;
    logic [CNT_W:0]   strobe_run;

    assign strobe_any = rd_strobe || wr_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_run <= '0;
        end else if (strobe_any) begin
            strobe_run <= strobe_run + 1'b1;
        end else begin
            strobe_run <= '0;
        end
    end

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    assert_cs_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any ? $onehot(guest_cs) : (guest_cs == '0));

    assert_accept_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> strobe_any);

    assert_strobe_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_any && strobe_run != '0) |-> (strobe_run == {1'b0, lat_dur_cycles}));

    assert_no_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |-> !req_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!strobe_any && $past(strobe_any)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

    assert_busy_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy != req_ready);

endmodule

// File: tb/guest_strobe_gen_tb.sv
module guest_strobe_gen_tb;

    typedef struct {
        int          guest;
        bit          wr;
        int          dur;
        int          rec;
        logic [15:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timing_cfg = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_guest = '0;
    logic        req_write = 1'b0;
    logic        req_ready, busy, rd_strobe, wr_strobe, done;
    logic [3:0]  guest_cs;
    logic [15:0] rd_data_in = '0;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int pushed  = 0;
    int popped_done = 0;
    bit finished = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    guest_strobe_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .timing_cfg (timing_cfg),
        .req_valid  (req_valid),
        .req_guest  (req_guest),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .busy       (busy),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .guest_cs   (guest_cs),
        .done       (done),
        .rd_data_in (rd_data_in),
        .rd_data    (rd_data)
    );

    function automatic int code_cycles(input logic [1:0] c);
        case (c)
            2'b00:   return 3;
            2'b01:   return 4;
            2'b10:   return 12;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: pushes expected items, then presents the request
    task automatic access(input int g, input bit wr, input logic [15:0] cfg,
                          input logic [15:0] data, input bit mid_change, input bit poke);
        item_t it;
        logic [3:0] nib;
        while (!req_ready) @(negedge clk);
        nib = cfg[g*4 +: 4];
        it.guest = g;
        it.wr    = wr;
        it.dur   = code_cycles(nib[3:2]);   // R3 duration bits
        it.rec   = code_cycles(nib[1:0]);   // R3 recovery bits
        it.data  = data;
        q.push_back(it);
        pushed++;
        timing_cfg = cfg;
        rd_data_in = data;
        req_guest  = 2'(g);
        req_write  = wr;
        req_valid  = 1'b1;
        @(posedge clk); #1;
        chk((rd_strobe | wr_strobe) == 1'b1, "R4 strobe after accept", int'(rd_strobe | wr_strobe), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_change) timing_cfg = ~cfg;   // R7
        if (poke) begin                       // R6
            req_valid = 1'b1;
            req_guest = 2'(g + 1);
            req_write = ~wr;
            for (int i = 0; i < 2; i++) begin
                chk(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        bit    prev_s = 1'b0;
        bit    in_rec = 1'b0;
        int    run = 0;
        int    reclen = 0;
        item_t cur;
        logic [15:0] exp_rd = '0;
        bit    s;
        cur = '{guest: 0, wr: 1'b0, dur: 0, rec: 0, data: '0};
        forever begin
            @(posedge clk); #1;
            if (!rst_n) continue;
            s = rd_strobe | wr_strobe;
            if (s && !prev_s) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    cur = q.pop_front();
                end
                run = 1;
            end else if (s) begin
                run++;
            end
            if (s) begin
                if (guest_cs != (4'b1 << cur.guest) || rd_strobe != !cur.wr || wr_strobe != cur.wr)
                    chk(1'b0, "R4 chip select/direction", int'(guest_cs), int'(4'b1 << cur.guest));
            end
            if (!s && prev_s) begin
                chk(run == cur.dur, "R2/R4/R7 strobe length", run, cur.dur);
                chk(done == 1'b1, "R8 done at strobe end", int'(done), 1);
                if (!cur.wr) exp_rd = cur.data;
                chk(rd_data == exp_rd, "R9 read data", int'(rd_data), int'(exp_rd));
                chk(busy == !req_ready, "R10 busy inverse", int'(busy), int'(!req_ready));
                in_rec = 1'b1;
                reclen = 0;
            end else if (done) begin
                chk(1'b0, "R8 stray done", 1, 0);
            end
            if (in_rec) begin
                if (!req_ready) begin
                    reclen++;
                end else begin
                    chk(reclen == cur.rec, "R5/R7 recovery length", reclen, cur.rec);
                    in_rec = 1'b0;
                    popped_done++;
                end
            end
            prev_s = s;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk((rd_strobe | wr_strobe) == 1'b0, "R1 strobe", int'(rd_strobe | wr_strobe), 0);
        chk(guest_cs == 4'h0, "R1 cs", int'(guest_cs), 0);
        chk(done == 1'b0 && rd_data == 16'h0, "R1 done/data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        access(0, 1'b0, 16'h0000, 16'hA5A5, 1'b0, 1'b0);  // R2 default 3/3
        access(1, 1'b1, 16'h0060, 16'h1111, 1'b0, 1'b0);  // R3 guest1 dur 01 rec 10
        access(2, 1'b0, 16'h3F00, 16'h5AC3, 1'b0, 1'b0);  // R3 guest2 dur 11 rec 11
        access(3, 1'b1, 16'h9E27, 16'h2222, 1'b0, 1'b0);  // R3 guest3 dur 10 rec 01
        access(3, 1'b0, 16'h4BD1, 16'h0F0F, 1'b1, 1'b0);  // R7 config changes mid-access
        access(0, 1'b0, 16'hC3A9, 16'h7E81, 1'b0, 1'b1);  // R6 poke while busy
        access(1, 1'b1, 16'h00C0, 16'hDEAD, 1'b0, 1'b0);  // R9 write keeps read data
        access(2, 1'b0, 16'h0E00, 16'h3C3C, 1'b0, 1'b0);  // R9 read updates data

        while (popped_done < pushed) @(negedge clk);
        chk(q.size() == 0, "R6 no leftover items", q.size(), 0);
        chk(req_ready == 1'b1 && busy == 1'b0, "R10 idle at end", int'(busy), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule